// File: doc/BRIEF.md
# PMIC Control Register Target on a Two-Wire Serial Bus

This block is the serial-bus register target of a supply controller. A host reaches it over a standard two-wire bus with 7-bit addressing. Through it the host programs two control registers and reads one status register. The upper six address bits are fixed by a parameter. The lowest address bit comes from the `addr_sel` pin, so two controllers can share a bus. SCL and SDA come in raw and pass through a synchroniser inside the block. SDA is driven open-drain through `sda_oe`, where 1 pulls the line low. Every control field is decoded onto its own output pin.

The protection logic feeds live condition inputs into the block. Two of them, over-temperature shutdown and over-current, are latched. While either latched bit is set, the active-low `fault_n` pin is held low. A latched bit is released only when the host has read the status byte that reported it. The other status bits follow their inputs directly. Control registers can be written at any time, even while the output-enable bit is 0.

Top module: `pmic_i2c_target`

## Requirements
- R1: The block answers only to the 7-bit address `{ADDR_HI, addr_sel}`, which is 0x60 with `addr_sel` low and 0x61 with it high. It does not acknowledge any other address and ignores the rest of that transfer, so registers are left unchanged.
- R2: For each byte it accepts (the address, the register pointer and the write data), the block pulls SDA low for the ninth SCL pulse. It releases SDA on the falling SCL edge that ends that pulse.
- R3: A write is START, address+0, pointer, data, STOP. The new register value reaches the outputs on the falling SCL edge of the data byte's last bit, and not before. This also applies while the output-enable bit is 0.
- R4: A read is START, address+0, pointer, repeated START, address+1. The block then shifts out the addressed register most significant bit first, and a host NACK ends the transfer.
- R5: Register 0x00 resets to 0x08. Bit 7 is `host_ctl`, bit 6 is a spare stored bit, bit 5 is `tone_gate`, bit 4 is `tone_int`, bit 3 is `out_en` and bits 2:0 are `vsel`.
- R6: Register 0x01 resets to 0x09. Bits 4:3 are `tone_pos`, bits 2:1 are `ilim_code` and bit 0 is `ilim_ext`. Bits 7:5 are not stored and read as 0.
- R7: Register 0x02 reads as {0, `t125_i`, `ldo_on_i`, 0, TSD, OCP, `cable_ok_i`, `vout_ok_i`}, bit 7 first. Writes to it are acknowledged but change nothing.
- R8: The TSD and OCP bits set one clock after `tsd_i` or `ocp_i` is high. While either bit is set, `fault_n` is low. A set bit stays set until the last bit of a status byte reporting it has been shifted out. If the input is still high at that point, the bit stays set.
- R9: The bits T125, LDO_ON, CABLE_GOOD and VOUT_GOOD follow their inputs without latching.
- R10: Reads of any pointer above 0x02 return 0x00. Writes to such a pointer are acknowledged and discarded.
- R11: A STOP returns the block to idle and releases SDA in the next clock.
- R12: A fault that arrives after the status byte was loaded for sending is not cleared by that read. It is reported by the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock |
| sda_i | input | 1 | Raw bus data |
| addr_sel | input | 1 | Target address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| t125_i | input | 1 | Die above warning temperature |
| ldo_on_i | input | 1 | Linear stage running |
| tsd_i | input | 1 | Thermal shutdown condition |
| ocp_i | input | 1 | Over-current protection condition |
| cable_ok_i | input | 1 | Load current present |
| vout_ok_i | input | 1 | Output voltage in window |
| host_ctl | output | 1 | Register control selected |
| tone_gate | output | 1 | Tone gating on |
| tone_int | output | 1 | Internal tone source |
| out_en | output | 1 | Supply output enabled |
| vsel | output | 3 | Output voltage code |
| tone_pos | output | 2 | Tone placement code |
| ilim_code | output | 2 | Current-limit code |
| ilim_ext | output | 1 | Resistor sets current limit |
| fault_n | output | 1 | Low while a latched fault is set |

## Verification
A wrong protocol state shows up at the bus within the current byte. It appears as a missing or misplaced acknowledge, a data bit that comes out shifted, or SDA held low after STOP. A wrong register or field mapping shows up on the decoded pins and in the read-back byte of the very next transaction. A fault in the latch logic shows up on `fault_n`. The pin either rises without a status read, or stays low once the read has reported the bit. Each of these is visible within one status-read transaction.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_DACK,
    ST_TX,
    ST_HACK,
    ST_SKIP
  } bus_st_t;

  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  PTR_CTL0 = 8'h00;
  localparam logic [7:0]  PTR_CTL1 = 8'h01;
  localparam logic [7:0]  PTR_STAT = 8'h02;
  localparam logic [7:0]  CTL0_RST = 8'h08;
  localparam logic [4:0]  CTL1_RST = 5'h09;

  function automatic logic [6:0] own_addr(input logic [5:0] hi, input logic sel);
    return {hi, sel};
  endfunction

  function automatic logic [7:0] stat_byte(input logic t125, input logic ldo,
                                           input logic tsd, input logic ocp,
                                           input logic cab, input logic vok);
    return {1'b0, t125, ldo, 1'b0, tsd, ocp, cab, vok};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_raw};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_raw};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import pmic_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b110000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic [7:0] wr_data,
  output logic       wr_stb,
  output logic       rd_load,
  output logic       rd_done
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh, tx;
  logic             rw, host_ack;
  logic             byte_end, rx_state;

  assign rx_state = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WDATA);
  assign byte_end = scl_fall && (cnt == FULL);
  assign wr_stb   = (st == ST_WDATA) && byte_end;
  assign rd_done  = (st == ST_TX) && byte_end;
  assign rd_load  = scl_fall && (((st == ST_AACK) && rw) || ((st == ST_HACK) && host_ack));
  assign wr_data  = sh;
  assign sda_oe   = (st == ST_AACK) || (st == ST_PACK) || (st == ST_DACK) ||
                    ((st == ST_TX) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
      ptr      <= '0;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else if (stop_det) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      if (rx_state) begin
        if (scl_rise && cnt < FULL) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (byte_end) begin
          cnt <= '0;
          case (st)
            ST_ADDR: begin
              if (sh[7:1] == own_addr(ADDR_HI, addr_sel)) begin
                st <= ST_AACK;
                rw <= sh[0];
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ptr <= sh;
              st  <= ST_PACK;
            end
            default: st <= ST_DACK;
          endcase
        end
      end else begin
        case (st)
          ST_AACK: if (scl_fall) begin
            st <= rw ? ST_TX : ST_PTR;
            if (rw) tx <= rd_byte;
          end
          ST_PACK: if (scl_fall) st <= ST_WDATA;
          ST_DACK: if (scl_fall) st <= ST_SKIP;
          ST_TX: begin
            if (scl_rise && cnt < FULL) begin
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              st  <= ST_HACK;
            end else if (scl_fall) begin
              tx <= {tx[6:0], 1'b0};
            end
          end
          ST_HACK: begin
            if (scl_rise) host_ack <= !sda_s;
            if (scl_fall) begin
              st <= host_ack ? ST_TX : ST_SKIP;
              if (host_ack) tx <= rd_byte;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmic_reg_bank.sv
module pmic_reg_bank
  import pmic_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ptr,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic       rd_load,
  input  logic       rd_done,
  input  logic       t125_i,
  input  logic       ldo_on_i,
  input  logic       tsd_i,
  input  logic       ocp_i,
  input  logic       cable_ok_i,
  input  logic       vout_ok_i,
  output logic [7:0] rd_byte,
  output logic [7:0] ctl0,
  output logic [4:0] ctl1,
  output logic       stat_clr,
  output logic       fault_n
);
  logic tsd_q, ocp_q, tsd_seen, ocp_seen;
  logic stat_sel;

  assign stat_sel = (ptr == PTR_STAT);
  assign stat_clr = rd_done && stat_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= CTL0_RST;
      ctl1 <= CTL1_RST;
    end else if (wr_stb) begin
      if (ptr == PTR_CTL0) ctl0 <= wr_data;
      if (ptr == PTR_CTL1) ctl1 <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsd_q    <= 1'b0;
      ocp_q    <= 1'b0;
      tsd_seen <= 1'b0;
      ocp_seen <= 1'b0;
    end else begin
      if (rd_load && stat_sel) begin
        tsd_seen <= tsd_q;
        ocp_seen <= ocp_q;
      end
      if (stat_clr) begin
        tsd_q <= (tsd_q & ~tsd_seen) | tsd_i;
        ocp_q <= (ocp_q & ~ocp_seen) | ocp_i;
      end else begin
        tsd_q <= tsd_q | tsd_i;
        ocp_q <= ocp_q | ocp_i;
      end
    end
  end

  always_comb begin
    case (ptr)
      PTR_CTL0: rd_byte = ctl0;
      PTR_CTL1: rd_byte = {3'b000, ctl1};
      PTR_STAT: rd_byte = stat_byte(t125_i, ldo_on_i, tsd_q, ocp_q, cable_ok_i, vout_ok_i);
      default:  rd_byte = 8'h00;
    endcase
  end

  assign fault_n = ~(tsd_q | ocp_q);
endmodule

// File: rtl/pmic_i2c_target.sv
module pmic_i2c_target
  import pmic_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b110000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  input  logic       t125_i,
  input  logic       ldo_on_i,
  input  logic       tsd_i,
  input  logic       ocp_i,
  input  logic       cable_ok_i,
  input  logic       vout_ok_i,
  output logic       host_ctl,
  output logic       tone_gate,
  output logic       tone_int,
  output logic       out_en,
  output logic [2:0] vsel,
  output logic [1:0] tone_pos,
  output logic [1:0] ilim_code,
  output logic       ilim_ext,
  output logic       fault_n
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_data, rd_byte, ctl0;
  logic [4:0] ctl1;
  logic       wr_stb, rd_load, rd_done, stat_clr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_byte(rd_byte), .sda_oe(sda_oe), .ptr(ptr),
    .wr_data(wr_data), .wr_stb(wr_stb), .rd_load(rd_load), .rd_done(rd_done)
  );

  pmic_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_data(wr_data), .wr_stb(wr_stb),
    .rd_load(rd_load), .rd_done(rd_done), .t125_i(t125_i), .ldo_on_i(ldo_on_i),
    .tsd_i(tsd_i), .ocp_i(ocp_i), .cable_ok_i(cable_ok_i), .vout_ok_i(vout_ok_i),
    .rd_byte(rd_byte), .ctl0(ctl0), .ctl1(ctl1), .stat_clr(stat_clr),
    .fault_n(fault_n)
  );

  assign host_ctl  = ctl0[7];
  assign tone_gate = ctl0[5];
  assign tone_int  = ctl0[4];
  assign out_en    = ctl0[3];
  assign vsel      = ctl0[2:0];
  assign tone_pos  = ctl1[4:3];
  assign ilim_code = ctl1[2:1];
  assign ilim_ext  = ctl1[0];
endmodule

// File: rtl/pmic_i2c_chk.sv
module pmic_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       wr_stb,
  input logic       stat_clr,
  input logic       sda_oe,
  input logic       tsd_i,
  input logic       ocp_i,
  input logic       fault_n,
  input logic [7:0] ctl_view,
  input logic [4:0] ctl1_view
);
  // R3
  wr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> scl_fall);

  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({ctl_view, ctl1_view}));

  // R8
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_i || ocp_i) |=> !fault_n);

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !stat_clr) |=> !fault_n);

  // R8
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(stat_clr));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind pmic_i2c_target pmic_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .stop_det(stop_det),
  .wr_stb(wr_stb), .stat_clr(stat_clr), .sda_oe(sda_oe), .tsd_i(tsd_i),
  .ocp_i(ocp_i), .fault_n(fault_n),
  .ctl_view({host_ctl, 1'b0, tone_gate, tone_int, out_en, vsel}),
  .ctl1_view({tone_pos, ilim_code, ilim_ext})
);

// File: tb/tb_pmic_i2c_target.sv
module tb_pmic_i2c_target;
  localparam int Q = 10;
  localparam logic [6:0] A0 = 7'h60;
  localparam logic [6:0] A1 = 7'h61;
  // {pointer, write data, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h01, 8'hFF, 8'h1F},
    {8'h01, 8'h12, 8'h12},
    {8'h00, 8'h00, 8'h00},
    {8'h01, 8'h06, 8'h06},
    {8'h05, 8'h77, 8'h00},
    {8'h02, 8'hFF, 8'h00},
    {8'h00, 8'h3C, 8'h3C}
  };

  logic clk = 0, rst_n = 0;
  logic host_scl = 1, host_sda = 1, addr_sel = 0;
  logic t125_i = 0, ldo_on_i = 0, tsd_i = 0, ocp_i = 0, cable_ok_i = 0, vout_ok_i = 0;
  logic sda_oe, host_ctl, tone_gate, tone_int, out_en, ilim_ext, fault_n;
  logic [2:0] vsel;
  logic [1:0] tone_pos, ilim_code;
  wire sda_line = host_sda & ~sda_oe;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  pmic_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .t125_i(t125_i), .ldo_on_i(ldo_on_i), .tsd_i(tsd_i), .ocp_i(ocp_i),
    .cable_ok_i(cable_ok_i), .vout_ok_i(vout_ok_i), .host_ctl(host_ctl),
    .tone_gate(tone_gate), .tone_int(tone_int), .out_en(out_en), .vsel(vsel),
    .tone_pos(tone_pos), .ilim_code(ilim_code), .ilim_ext(ilim_ext), .fault_n(fault_n)
  );

  function automatic logic [7:0] ctl0_pins();
    return {host_ctl, 1'b0, tone_gate, tone_int, out_en, vsel};
  endfunction
  function automatic logic [7:0] ctl1_pins();
    return {3'b000, tone_pos, ilim_code, ilim_ext};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic bus_start;
    host_sda = 1; wq; host_scl = 1; wq; host_sda = 0; wq; host_scl = 0; wq;
  endtask
  task automatic bus_stop;
    host_sda = 0; wq; host_scl = 1; wq; host_sda = 1; wq;
  endtask
  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq; host_scl = 1; wq; wq; host_scl = 0; wq;
    end
  endtask
  task automatic get_ack(output logic ack);
    host_sda = 1; wq; host_scl = 1; wq; ack = !sda_line; wq; host_scl = 0; wq;
  endtask
  task automatic recv_byte(input logic inj, output logic [7:0] d);
    host_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; host_scl = 1; wq; d[i] = sda_line;
      if (inj && i == 3) begin ocp_i = 1; @(negedge clk); ocp_i = 0; end
      wq; host_scl = 0;
    end
    wq; host_sda = 1; wq; host_scl = 1; wq; wq; host_scl = 0; wq;
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           output logic ok);
    logic k1, k2, k3;
    bus_start; send_bits({a, 1'b0}); get_ack(k1);
    send_bits(p); get_ack(k2); send_bits(d); get_ack(k3); bus_stop;
    ok = k1 & k2 & k3;
  endtask

  task automatic read_reg(input logic [6:0] a, input logic [7:0] p, input logic inj,
                          output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start; send_bits({a, 1'b0}); get_ack(k1); send_bits(p); get_ack(k2);
    bus_start; send_bits({a, 1'b1}); get_ack(k3); recv_byte(inj, d); bus_stop;
    ok = k1 & k2 & k3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11 actual running expected finished");
    report;
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R5 R6 R8 reset state at the pins
    chk("R5 reset ctl0 pins", ctl0_pins(), 8'h08);
    chk("R6 reset ctl1 pins", ctl1_pins(), 8'h09);
    chk("R8 reset fault_n", {7'd0, fault_n}, 8'h01);
    chk("R11 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    read_reg(A0, 8'h00, 0, d, ok);
    chk("R5 R4 reset read ctl0", d, 8'h08);
    chk("R2 read acks", {7'd0, ok}, 8'h01);
    read_reg(A0, 8'h01, 0, d, ok);
    chk("R6 reset read ctl1", d, 8'h09);

    // vector table: write then read back
    for (int v = 0; v < 8; v++) begin
      write_reg(A0, VEC[v][23:16], VEC[v][15:8], ok);
      chk("R2 R3 R10 write acked", {7'd0, ok}, 8'h01);
      if (VEC[v][23:16] == 8'h00) chk("R5 ctl0 pins", ctl0_pins(), VEC[v][15:8] & 8'hBF);
      if (VEC[v][23:16] == 8'h01) chk("R6 ctl1 pins", ctl1_pins(), VEC[v][15:8] & 8'h1F);
      read_reg(A0, VEC[v][23:16], 0, d, ok);
      chk("R4 R7 R10 read back", d, VEC[v][7:0]);
    end
    chk("R11 idle after stop", {7'd0, sda_oe}, 8'h00);

    // R3 write lands on falling edge of the last data bit, even with out_en 0
    write_reg(A0, 8'h00, 8'h00, ok);
    bus_start; send_bits({A0, 1'b0}); get_ack(ok); send_bits(8'h00); get_ack(ok);
    for (int i = 7; i >= 1; i--) begin
      host_sda = 1'b1 ^ (i == 7); wq; host_scl = 1; wq; wq; host_scl = 0; wq;
    end
    host_sda = 1; wq; host_scl = 1; wq;
    chk("R3 not yet applied", ctl0_pins(), 8'h00);
    wq; host_scl = 0; wq;
    chk("R3 applied at last-bit fall", ctl0_pins(), 8'h3F);
    get_ack(ok); chk("R2 data ack", {7'd0, ok}, 8'h01);
    bus_stop;

    // R1 address selection
    addr_sel = 1;
    write_reg(A0, 8'h00, 8'h11, ok);
    chk("R1 0x60 ignored when pin high", {7'd0, ok}, 8'h00);
    chk("R1 no write from foreign address", ctl0_pins(), 8'h3F);
    write_reg(A1, 8'h00, 8'h82, ok);
    chk("R1 0x61 answered when pin high", {7'd0, ok}, 8'h01);
    chk("R1 write via 0x61", ctl0_pins(), 8'h82);
    addr_sel = 0;
    write_reg(A1, 8'h00, 8'h0C, ok);
    chk("R1 0x61 ignored when pin low", {7'd0, ok}, 8'h00);
    chk("R1 ctl0 untouched", ctl0_pins(), 8'h82);

    // R9 live status bits
    t125_i = 1; ldo_on_i = 1; cable_ok_i = 1; vout_ok_i = 1;
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R9 R7 live bits set", d, 8'h63);
    t125_i = 0; cable_ok_i = 0;
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R9 live bits follow", d, 8'h21);
    ldo_on_i = 0; vout_ok_i = 0;

    // R8 sticky OCP
    ocp_i = 1; @(negedge clk); ocp_i = 0; repeat (20) @(negedge clk);
    chk("R8 fault_n low after ocp", {7'd0, fault_n}, 8'h00);
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R8 ocp reported", d, 8'h04);
    chk("R8 fault_n released after read", {7'd0, fault_n}, 8'h01);
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R8 ocp cleared", d, 8'h00);

    // R8 sticky TSD with condition still present
    tsd_i = 1; repeat (3) @(negedge clk);
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R8 tsd reported", d, 8'h08);
    chk("R8 fault held while tsd present", {7'd0, fault_n}, 8'h00);
    tsd_i = 0;
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R8 tsd set again", d, 8'h08);
    chk("R8 fault released", {7'd0, fault_n}, 8'h01);

    // R12 fault arriving mid-read survives that read
    read_reg(A0, 8'h02, 1, d, ok);
    chk("R12 mid-read byte snapshot", d, 8'h00);
    chk("R12 fault kept", {7'd0, fault_n}, 8'h00);
    read_reg(A0, 8'h02, 0, d, ok);
    chk("R12 reported on next read", d, 8'h04);
    chk("R12 released", {7'd0, fault_n}, 8'h01);
    chk("R11 sda released at end", {7'd0, sda_oe}, 8'h00);

    report;
    $finish;
  end
endmodule